// File: doc/BRIEF.md
# GCI Downstream Channel Demultiplexer

This block takes the downstream serial data of a GCI highway and pulls out one of its channels. The highway carries a 256-bit frame every 125 µs at 2.048 Mb/s. The frame holds eight channels of four bytes each. A frame sync input marks the first bit of channel 0. A data clock running at twice the bit rate times every bit. Two strap pins choose which of the first four channels the block extracts.

The block sorts the four bytes of the chosen channel by their position. The two compressed voice bytes go out on a voice port, which feeds the expander. The monitor byte and the signalling/control byte go out on a control port, which feeds the control logic. Each byte appears for one cycle with a valid strobe and a one-bit tag that says which of the pair it is.

The data clock, the frame sync, the data line and the strap pins are brought into the system clock domain by synchronizers. The system clock must run at least four times faster than the data clock.

Top module: `gci_dd_demux`

## Requirements
- R1: While reset is high, and in the cycle after it, both valid strobes are 0. After reset, both data outputs and both tags are 0 until the first byte arrives.
- R2: Before the first frame sync, no byte is produced. After the 256th bit of a frame, no byte is produced until the next frame sync rising edge.
- R3: A frame begins at the rising data-clock edge where frame sync is first seen high. Each bit lasts two data-clock periods and is sampled at the rising edge that starts its second period. Bits are assembled into bytes most significant bit first.
- R4: Channel n occupies frame bits 32n to 32n+31. The extracted channel index is {chan_sel_hi, chan_sel_lo}, so channels 0 to 3 can be chosen.
- R5: The bytes of a channel arrive in the order B1, B2, MON, SC. B1 and B2 leave on the voice port with voice_is_b2 = 0 and 1. MON and SC leave on the control port with ctrl_is_sc = 0 and 1.
- R6: Each byte produces a valid pulse that lasts exactly one cycle. voice_vld and ctrl_vld are never high in the same cycle.
- R7: A frame sync rising edge that arrives before 256 bits have been received restarts the frame at bit 0. The byte that was partly received is discarded.
- R8: The channel select is captured at each frame start. A change on the select pins in the middle of a frame takes effect only from the next frame.
- R9: Bits that arrive after the 256th bit of a frame and before a late frame sync are ignored.
- R10: Bytes of channels other than the selected one never appear on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the data clock |
| rst | input | 1 | Synchronous active-high reset |
| gci_dclk | input | 1 | Data clock at twice the bit rate (asynchronous) |
| gci_fsync | input | 1 | Frame sync; a rising edge marks bit 0 of channel 0 |
| gci_dd | input | 1 | Downstream serial data |
| chan_sel_lo | input | 1 | Channel select, low bit |
| chan_sel_hi | input | 1 | Channel select, high bit |
| voice_vld | output | 1 | One-cycle strobe for a voice byte |
| voice_byte | output | 8 | Compressed voice byte |
| voice_is_b2 | output | 1 | 0 = first voice byte (B1), 1 = second (B2) |
| ctrl_vld | output | 1 | One-cycle strobe for a control-path byte |
| ctrl_byte | output | 8 | Monitor or signalling/control byte |
| ctrl_is_sc | output | 1 | 0 = monitor byte, 1 = signalling/control byte |

## Verification
The hardest state to reach is a frame that ends off the 256-bit count. This happens when frame sync returns in the middle of a byte of the selected channel, or when it comes late after stray bits that would otherwise look like the start of channel 0. The driver builds both cases on purpose. It cuts one frame three bits into its B2 byte while channel 1 is selected. It pads another frame with twenty extra one-bits while channel 0 is selected. In each case only the bytes that are still legitimate are placed in the scoreboard. A change of the select pins halfway through a frame is driven as well. The scoreboard expects the old channel in that frame and the new channel in the next one.

// File: rtl/gci_dd_pkg.sv
package gci_dd_pkg;

    localparam int FRAME_BITS = 256;
    localparam int BYTE_BITS  = 8;
    localparam int CH_BYTES   = 4;
    localparam int SEL_W      = 2;
    localparam int CHANNELS   = FRAME_BITS / (BYTE_BITS * CH_BYTES);
    localparam int BIT_CNT_W  = $clog2(FRAME_BITS);
    localparam int IN_BYTE_W  = $clog2(BYTE_BITS);
    localparam int SLOT_W     = $clog2(CH_BYTES);
    localparam int CH_W       = $clog2(CHANNELS);

    typedef enum logic [SLOT_W-1:0] {
        SLOT_B1  = 2'd0,
        SLOT_B2  = 2'd1,
        SLOT_MON = 2'd2,
        SLOT_SC  = 2'd3
    } slot_e;

    typedef struct packed {
        logic                 vld;
        logic [CH_W-1:0]      chan;
        slot_e                slot;
        logic [BYTE_BITS-1:0] data;
    } rx_byte_t;

    function automatic logic slot_is_voice(input slot_e s);
        return (s == SLOT_B1) || (s == SLOT_B2);
    endfunction

    function automatic logic slot_second_of_pair(input slot_e s);
        return (s == SLOT_B2) || (s == SLOT_SC);
    endfunction

endpackage

// File: rtl/gci_dd_sync.sv
module gci_dd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= async_i;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else begin
                    chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/gci_dd_framer.sv
module gci_dd_framer
    import gci_dd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 fsc,
    input  logic [SEL_W-1:0]     sel,
    output logic                 frame_start,
    output logic                 sample,
    output logic                 frame_active,
    output logic [BIT_CNT_W-1:0] bit_cnt,
    output logic [SEL_W-1:0]     sel_q
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

    logic fsc_prev;
    logic mid_next;

    assign frame_start = tick && fsc && !fsc_prev;
    assign sample      = tick && frame_active && mid_next && !frame_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsc_prev     <= 1'b0;
            mid_next     <= 1'b0;
            frame_active <= 1'b0;
            bit_cnt      <= '0;
            sel_q        <= '0;
        end else if (tick) begin
            fsc_prev <= fsc;
            if (frame_start) begin
                bit_cnt      <= '0;
                mid_next     <= 1'b1;
                frame_active <= 1'b1;
                sel_q        <= sel;
            end else if (frame_active) begin
                if (mid_next) begin
                    mid_next <= 1'b0;
                    bit_cnt  <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        frame_active <= 1'b0;
                    end
                end else begin
                    mid_next <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gci_dd_shifter.sv
module gci_dd_shifter
    import gci_dd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample,
    input  logic                 bit_in,
    input  logic [BIT_CNT_W-1:0] bit_cnt,
    output rx_byte_t             byte_o
);

    localparam logic [IN_BYTE_W-1:0] LAST_IN_BYTE = '1;

    logic [BYTE_BITS-2:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            byte_o <= '0;
        end else begin
            byte_o.vld <= 1'b0;
            if (sample) begin
                acc <= {acc[BYTE_BITS-3:0], bit_in};
                if (bit_cnt[IN_BYTE_W-1:0] == LAST_IN_BYTE) begin
                    byte_o.vld  <= 1'b1;
                    byte_o.data <= {acc, bit_in};
                    byte_o.chan <= bit_cnt[BIT_CNT_W-1 -: CH_W];
                    byte_o.slot <= slot_e'(bit_cnt[IN_BYTE_W +: SLOT_W]);
                end
            end
        end
    end

endmodule

// File: rtl/gci_dd_router.sv
module gci_dd_router
    import gci_dd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rx_byte_t             byte_i,
    input  logic [SEL_W-1:0]     sel_q,
    output logic                 voice_vld,
    output logic [BYTE_BITS-1:0] voice_byte,
    output logic                 voice_is_b2,
    output logic                 ctrl_vld,
    output logic [BYTE_BITS-1:0] ctrl_byte,
    output logic                 ctrl_is_sc
);

    logic hit;
    logic to_voice;

    assign hit      = byte_i.vld && (byte_i.chan == CH_W'(sel_q));
    assign to_voice = slot_is_voice(byte_i.slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            voice_vld   <= 1'b0;
            voice_byte  <= '0;
            voice_is_b2 <= 1'b0;
            ctrl_vld    <= 1'b0;
            ctrl_byte   <= '0;
            ctrl_is_sc  <= 1'b0;
        end else begin
            voice_vld <= hit && to_voice;
            ctrl_vld  <= hit && !to_voice;
            if (hit && to_voice) begin
                voice_byte  <= byte_i.data;
                voice_is_b2 <= slot_second_of_pair(byte_i.slot);
            end
            if (hit && !to_voice) begin
                ctrl_byte  <= byte_i.data;
                ctrl_is_sc <= slot_second_of_pair(byte_i.slot);
            end
        end
    end

endmodule

// File: rtl/gci_dd_demux.sv
module gci_dd_demux
    import gci_dd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gci_dclk,
    input  logic                 gci_fsync,
    input  logic                 gci_dd,
    input  logic                 chan_sel_lo,
    input  logic                 chan_sel_hi,
    output logic                 voice_vld,
    output logic [BYTE_BITS-1:0] voice_byte,
    output logic                 voice_is_b2,
    output logic                 ctrl_vld,
    output logic [BYTE_BITS-1:0] ctrl_byte,
    output logic                 ctrl_is_sc
);

    localparam int PIN_W = 3 + SEL_W;

    logic [PIN_W-1:0]     pins_async;
    logic [PIN_W-1:0]     pins_sync;
    logic                 dclk_s;
    logic                 dclk_d;
    logic                 fsc_s;
    logic                 dd_s;
    logic [SEL_W-1:0]     sel_s;
    logic                 tick;
    logic                 frame_start;
    logic                 sample;
    logic                 frame_active;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [SEL_W-1:0]     sel_q;
    rx_byte_t             rx_byte;

    assign pins_async = {chan_sel_hi, chan_sel_lo, gci_dd, gci_fsync, gci_dclk};

    gci_dd_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_async),
        .sync_o  (pins_sync)
    );

    assign dclk_s = pins_sync[0];
    assign fsc_s  = pins_sync[1];
    assign dd_s   = pins_sync[2];
    assign sel_s  = pins_sync[PIN_W-1:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_d <= 1'b0;
        end else begin
            dclk_d <= dclk_s;
        end
    end

    assign tick = dclk_s && !dclk_d;

    gci_dd_framer i_framer (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .fsc          (fsc_s),
        .sel          (sel_s),
        .frame_start  (frame_start),
        .sample       (sample),
        .frame_active (frame_active),
        .bit_cnt      (bit_cnt),
        .sel_q        (sel_q)
    );

    gci_dd_shifter i_shifter (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .bit_in  (dd_s),
        .bit_cnt (bit_cnt),
        .byte_o  (rx_byte)
    );

    gci_dd_router i_router (
        .clk         (clk),
        .rst         (rst),
        .byte_i      (rx_byte),
        .sel_q       (sel_q),
        .voice_vld   (voice_vld),
        .voice_byte  (voice_byte),
        .voice_is_b2 (voice_is_b2),
        .ctrl_vld    (ctrl_vld),
        .ctrl_byte   (ctrl_byte),
        .ctrl_is_sc  (ctrl_is_sc)
    );

endmodule

// File: rtl/gci_dd_demux_chk.sv
module gci_dd_demux_chk
    import gci_dd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             voice_vld,
    input logic             ctrl_vld,
    input logic             frame_active,
    input logic             frame_start,
    input logic [SEL_W-1:0] sel_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!voice_vld && !ctrl_vld));

    // R6
    voice_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        voice_vld |=> !voice_vld);

    // R6
    ctrl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_vld |=> !ctrl_vld);

    // R6
    port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(voice_vld && ctrl_vld));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (voice_vld || ctrl_vld) |-> $past(frame_active, 2));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(sel_q));

endmodule

bind gci_dd_demux gci_dd_demux_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .voice_vld    (voice_vld),
    .ctrl_vld     (ctrl_vld),
    .frame_active (frame_active),
    .frame_start  (frame_start),
    .sel_q        (sel_q)
);

// File: tb/test_gci_dd_demux.sv
module test_gci_dd_demux;

    typedef struct {
        bit         is_ctrl;
        bit         tag;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0;
    logic       fsc = 1'b0;
    logic       dd = 1'b0;
    logic       sel_lo = 1'b0;
    logic       sel_hi = 1'b0;
    logic       voice_vld;
    logic [7:0] voice_byte;
    logic       voice_is_b2;
    logic       ctrl_vld;
    logic [7:0] ctrl_byte;
    logic       ctrl_is_sc;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   prev_v = 1'b0;
    bit   prev_c = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    gci_dd_demux i_gci_dd_demux (
        .clk         (clk),
        .rst         (rst),
        .gci_dclk    (dclk),
        .gci_fsync   (fsc),
        .gci_dd      (dd),
        .chan_sel_lo (sel_lo),
        .chan_sel_hi (sel_hi),
        .voice_vld   (voice_vld),
        .voice_byte  (voice_byte),
        .voice_is_b2 (voice_is_b2),
        .ctrl_vld    (ctrl_vld),
        .ctrl_byte   (ctrl_byte),
        .ctrl_is_sc  (ctrl_is_sc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // One bit = two data-clock periods, 16 system clocks
    task automatic drive_bit(input logic b, input logic f);
        @(negedge clk);
        dclk = 1'b1; dd = b; fsc = f;
        repeat (4) @(negedge clk);
        dclk = 1'b0;
        repeat (4) @(negedge clk);
        dclk = 1'b1;
        repeat (4) @(negedge clk);
        dclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] frame_byte(input int fidx, input int i);
        return 8'((fidx * 53) + (i * 29) + 7);
    endfunction

    // Pushes the expected bytes of the latched channel, then drives nbits
    task automatic send_frame(input int fidx, input int sel0, input int nbits,
                              input int sel_at, input int sel_new, input string req);
        {sel_hi, sel_lo} = 2'(sel0);
        for (int k = 0; k < 4; k++) begin
            exp_t e;
            if (32 * sel0 + 8 * k + 7 < nbits) begin
                e.is_ctrl = (k >= 2);
                e.tag     = k[0];
                e.data    = frame_byte(fidx, 4 * sel0 + k);
                e.req     = req;
                expq.push_back(e);
            end
        end
        for (int b = 0; b < nbits; b++) begin
            logic [7:0] v;
            if (b == sel_at) {sel_hi, sel_lo} = 2'(sel_new);
            v = frame_byte(fidx, b / 8);
            drive_bit(v[7 - (b % 8)], (b == 0));
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (voice_vld || ctrl_vld) begin
                check(!(voice_vld && ctrl_vld), "R6", "both ports valid", 1, 0);
                check(!(voice_vld && prev_v) && !(ctrl_vld && prev_c), "R6",
                      "strobe longer than one cycle", 1, 0);
                if (expq.size() == 0) begin
                    check(1'b0, "R2 R10", "unexpected byte",
                          voice_vld ? int'(voice_byte) : int'(ctrl_byte), 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(ctrl_vld == e.is_ctrl, e.req, "port (1=ctrl)",
                          int'(ctrl_vld), int'(e.is_ctrl));
                    check((ctrl_vld ? ctrl_is_sc : voice_is_b2) == e.tag, e.req,
                          "byte tag", int'(ctrl_vld ? ctrl_is_sc : voice_is_b2),
                          int'(e.tag));
                    check((ctrl_vld ? ctrl_byte : voice_byte) == e.data, e.req,
                          "byte value", int'(ctrl_vld ? ctrl_byte : voice_byte),
                          int'(e.data));
                end
            end
            prev_v = voice_vld;
            prev_c = ctrl_vld;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(voice_vld == 1'b0, "R1", "voice_vld after reset", int'(voice_vld), 0);
        check(ctrl_vld == 1'b0, "R1", "ctrl_vld after reset", int'(ctrl_vld), 0);
        check(voice_byte == 8'h00, "R1", "voice_byte after reset", int'(voice_byte), 0);
        check(ctrl_byte == 8'h00, "R1", "ctrl_byte after reset", int'(ctrl_byte), 0);

        // R2: bits without any frame sync produce nothing
        for (int b = 0; b < 40; b++) drive_bit(b[0], 1'b0);

        // R3 R4 R5: full frames on several channels
        send_frame(0, 0, 256, -1, 0, "R3 R4 R5");
        send_frame(1, 1, 256, -1, 0, "R3 R4 R5");
        send_frame(2, 3, 256, -1, 0, "R4 R5 R10");
        // R8: select moves mid-frame, old channel kept until next frame
        send_frame(3, 2, 256, 100, 3, "R8");
        send_frame(4, 3, 256, -1, 0, "R8");
        // R7: early sync three bits into B2 of channel 1
        send_frame(5, 1, 43, -1, 0, "R7");
        send_frame(6, 1, 256, -1, 0, "R7");
        // R9: late sync after twenty stray one-bits
        send_frame(7, 0, 256, -1, 0, "R9");
        for (int b = 0; b < 20; b++) drive_bit(1'b1, 1'b0);
        send_frame(8, 0, 256, -1, 0, "R9");

        for (int b = 0; b < 8; b++) drive_bit(1'b0, 1'b0);
        check(expq.size() == 0, "R2 R10", "expected bytes not produced",
              expq.size(), 0);
        finish_run();
    end

endmodule